// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address. It reads page-table entries from memory and walks a three-level radix tree. The lookup starts from a root-table address held on a plain control input. Each table is one 8 KB page of 1024 eight-byte entries. The walker issues at most one 64-bit entry read at a time on a small memory port. It ends every request with one response: a physical address, or a two-bit fault code.

Before any memory traffic, the walker checks three things about the address:

- that the upper bits are a clean sign extension;
- which segment the address falls in;
- whether a user-mode caller may touch that segment.

The kernel physical segment is not translated. Its low bits pass straight through as the physical address.

The request input, the memory read request and the response output are valid/ready handshakes:

- A request is taken only in a cycle where both `req_valid` and `req_ready` are high. `req_ready` is high only while the walker is idle.
- A memory read is held, with a steady address, until `mem_req_ready` accepts it.
- The memory read data comes back on `mem_rsp_valid` and cannot be stalled.
- A response holds its payload steady until `rsp_ready` takes it. The walker accepts a new request in the cycle after that.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and both `rsp_valid` and `mem_req_valid` are 0.
- R2: The level indices are VA[42:33], VA[32:23] and VA[22:13], used in that order. Each entry read address is the current table base plus index times 8, so bits [2:0] of the address are zero. The first base is `pt_root`. Each later base is the fetched entry's page number shifted left by 13.
- R3: Entry layout: bit 0 valid, bit 1 read allowed, bit 2 write allowed, bit 3 user allowed, and bits [63:32] the 32-bit physical page number.
- R4: An entry with bit 0 clear ends the walk at once with fault code 1 (invalid entry), and no further read is issued.
- R5: A successful walk returns code 0, with `rsp_pa` equal to {page number, VA[12:0]}. On any fault, `rsp_pa` is 0.
- R6: If VA[63:42] is neither all zeros nor all ones, the response is code 2 (non-canonical) and no memory read is issued.
- R7: Segment field VA[42:41]: 10 selects the kernel physical segment, which returns PA = VA[40:0] zero-extended with code 0 and no read. The values 11 (kernel virtual) and 00/01 (user) are walked.
- R8: With `req_user`=1, an address in segment 10 or 11 gives code 3 (protection) and issues no memory read.
- R9: On the last-level entry, a read needs bit 1, a write needs bit 2, and a user-mode access also needs bit 3. If any needed bit is missing, the response is code 3.
- R10: At most one memory read is outstanding. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready`, and after acceptance `mem_req_valid` stays low until the data returns.
- R11: While `rsp_valid` is high, `req_ready` is 0 and `rsp_pa`/`rsp_fault` stay steady until `rsp_ready`. In the cycle after the response handshake, `req_ready` is 1 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, able to take a request |
| req_va | input | 64 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| req_user | input | 1 | 1 when the access is from user mode |
| pt_root | input | 45 | Physical address of the first-level table |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 45 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Entry read data valid |
| mem_rsp_data | input | 64 | Entry read data |
| rsp_valid | output | 1 | Translation response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_pa | output | 45 | Translated physical address (0 on fault) |
| rsp_fault | output | 2 | 0 ok, 1 invalid entry, 2 non-canonical, 3 protection |

## Verification
The hardest cases to reach from the ports are a walk that stops at the second or third level, and a last-level entry that is valid but forbids the access. Both need a partially built table tree in the bench memory, so the bench shares its first- and second-level tables between several pages. It then probes neighbouring indices that have no entry, and pages whose rights bits leave out write or user. Memory acceptance stalls and held responses are switched on for part of the run. This shows the read request and the response staying steady while the walker waits.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  localparam int VA_W   = 64;
  localparam int LVL_W  = 10;
  localparam int N_LVL  = 3;
  localparam int OFF_W  = 13;
  localparam int PPN_W  = 32;
  localparam int PTE_W  = 64;
  localparam int PTE_LG = 3;
  localparam int XL_W   = N_LVL * LVL_W + OFF_W;
  localparam int PA_W   = PPN_W + OFF_W;
  localparam int KP_W   = XL_W - 2;
  localparam int UP_W   = VA_W - XL_W + 1;

  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_U = 3;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_CANON   = 2'd2,
    FLT_PROT    = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    S_IDLE, S_L1, S_L2, S_L3, S_DONE, S_FAULT
  } state_e;

  localparam logic [1:0] SEG_KPHYS = 2'b10;
endpackage

// File: rtl/pt_va_decode.sv
module pt_va_decode #(
  parameter int VA_W  = 64,
  parameter int LVL_W = 10,
  parameter int N_LVL = 3,
  parameter int OFF_W = 13,
  localparam int XL_W = N_LVL * LVL_W + OFF_W
) (
  input  logic [VA_W-1:0]        va,
  output logic                   canonical,
  output logic [1:0]             seg,
  output logic [N_LVL*LVL_W-1:0] idx_flat,
  output logic [OFF_W-1:0]       off
);
  logic [VA_W-XL_W:0] upper;

  assign upper     = va[VA_W-1:XL_W-1];
  assign canonical = (&upper) | ~(|upper);
  assign seg       = va[XL_W-1 -: 2];
  assign off       = va[OFF_W-1:0];

  // slot 0 holds the first-level index, taken from the top of the range
  for (genvar g = 0; g < N_LVL; g++) begin : g_idx
    assign idx_flat[g*LVL_W +: LVL_W] = va[XL_W-1-g*LVL_W -: LVL_W];
  end
endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int PA_W   = 45,
  parameter int LVL_W  = 10,
  parameter int PTE_LG = 3
) (
  input  logic [PA_W-1:0]  base,
  input  logic [LVL_W-1:0] idx,
  output logic [PA_W-1:0]  addr
);
  localparam int PAD = PA_W - LVL_W - PTE_LG;
  assign addr = base + {{PAD{1'b0}}, idx, {PTE_LG{1'b0}}};
endmodule

// File: rtl/pt_pte_check.sv
module pt_pte_check
  import pt_walk_pkg::*;
(
  input  logic [PTE_W-1:0] pte,
  input  logic             is_write,
  input  logic             is_user,
  output logic             vld,
  output logic             allow,
  output logic [PPN_W-1:0] ppn,
  output logic [PA_W-1:0]  next_base
);
  logic need_ok;

  assign vld       = pte[BIT_V];
  assign ppn       = pte[PTE_W-1 -: PPN_W];
  assign next_base = {ppn, {OFF_W{1'b0}}};
  assign need_ok   = is_write ? pte[BIT_W] : pte[BIT_R];
  assign allow     = need_ok & (~is_user | pte[BIT_U]);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_write,
  input  logic             req_user,
  input  logic [PA_W-1:0]  pt_root,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_pa,
  output logic [1:0]       rsp_fault
);
  state_e                 state;
  logic                   issued;
  logic [PA_W-1:0]        tbase;
  logic [N_LVL*LVL_W-1:0] idx_q;
  logic [OFF_W-1:0]       off_q;
  logic                   wr_q, usr_q;
  logic [PA_W-1:0]        pa_q;
  fault_e                 code_q;

  logic                   in_canon;
  logic [1:0]             in_seg;
  logic [N_LVL*LVL_W-1:0] in_idx;
  logic [OFF_W-1:0]       in_off;
  logic [LVL_W-1:0]       cur_idx;
  logic                   walking, last_lvl;
  logic                   pte_vld, pte_allow;
  logic [PPN_W-1:0]       pte_ppn;
  logic [PA_W-1:0]        pte_base;
  logic                   accept, pte_in;

  pt_va_decode #(.VA_W(VA_W), .LVL_W(LVL_W), .N_LVL(N_LVL), .OFF_W(OFF_W)) u_dec (
    .va(req_va), .canonical(in_canon), .seg(in_seg), .idx_flat(in_idx), .off(in_off)
  );

  always_comb begin
    cur_idx  = idx_q[0 +: LVL_W];
    walking  = 1'b0;
    last_lvl = 1'b0;
    case (state)
      S_L1: begin cur_idx = idx_q[0*LVL_W +: LVL_W]; walking = 1'b1; end
      S_L2: begin cur_idx = idx_q[1*LVL_W +: LVL_W]; walking = 1'b1; end
      S_L3: begin cur_idx = idx_q[2*LVL_W +: LVL_W]; walking = 1'b1; last_lvl = 1'b1; end
      default: ;
    endcase
  end

  pt_entry_addr #(.PA_W(PA_W), .LVL_W(LVL_W), .PTE_LG(PTE_LG)) u_addr (
    .base(tbase), .idx(cur_idx), .addr(mem_req_addr)
  );

  pt_pte_check u_pte (
    .pte(mem_rsp_data), .is_write(wr_q), .is_user(usr_q),
    .vld(pte_vld), .allow(pte_allow), .ppn(pte_ppn), .next_base(pte_base)
  );

  assign req_ready     = (state == S_IDLE);
  assign accept        = req_valid & req_ready;
  assign mem_req_valid = walking & ~issued;
  assign pte_in        = walking & issued & mem_rsp_valid;
  assign rsp_valid     = (state == S_DONE) | (state == S_FAULT);
  assign rsp_pa        = pa_q;
  assign rsp_fault     = code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      issued <= 1'b0;
      tbase  <= '0;
      idx_q  <= '0;
      off_q  <= '0;
      wr_q   <= 1'b0;
      usr_q  <= 1'b0;
      pa_q   <= '0;
      code_q <= FLT_NONE;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          idx_q  <= in_idx;
          off_q  <= in_off;
          wr_q   <= req_write;
          usr_q  <= req_user;
          issued <= 1'b0;
          tbase  <= pt_root;
          pa_q   <= '0;
          code_q <= FLT_NONE;
          if (!in_canon) begin
            code_q <= FLT_CANON;
            state  <= S_FAULT;
          end else if (req_user && in_seg[1]) begin
            code_q <= FLT_PROT;
            state  <= S_FAULT;
          end else if (in_seg == SEG_KPHYS) begin
            pa_q  <= {{(PA_W-KP_W){1'b0}}, req_va[KP_W-1:0]};
            state <= S_DONE;
          end else begin
            state <= S_L1;
          end
        end
        S_L1, S_L2, S_L3: begin
          if (mem_req_valid && mem_req_ready) issued <= 1'b1;
          if (pte_in) begin
            issued <= 1'b0;
            if (!pte_vld) begin
              code_q <= FLT_INVALID;
              state  <= S_FAULT;
            end else if (!last_lvl) begin
              tbase <= pte_base;
              state <= (state == S_L1) ? S_L2 : S_L3;
            end else if (!pte_allow) begin
              code_q <= FLT_PROT;
              state  <= S_FAULT;
            end else begin
              pa_q  <= {pte_ppn, off_q};
              state <= S_DONE;
            end
          end
        end
        S_DONE, S_FAULT: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R10
  single_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_fault));

  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R6
  canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !((&req_va[VA_W-1:XL_W-1]) || !(|req_va[VA_W-1:XL_W-1]))
    |=> rsp_valid && rsp_fault == FLT_CANON && !mem_req_valid);

  // R7
  kphys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_user && (&req_va[VA_W-1:XL_W-1])
      && req_va[XL_W-2] == 1'b0
    |=> rsp_valid && rsp_fault == FLT_NONE
        && rsp_pa == {{(PA_W-KP_W){1'b0}}, $past(req_va[KP_W-1:0])});

  // R5
  fault_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault != FLT_NONE |-> rsp_pa == '0);
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic [44:0] pt_root = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [44:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [44:0] rsp_pa;
  logic [1:0]  rsp_fault;

  int checks = 0;
  int errors = 0;
  int nreads = 0;
  int lat_cfg = 0;
  int cyc = 0;
  bit stall = 1'b0;
  bit multi_err = 1'b0;

  always #4 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .req_write(req_write), .req_user(req_user), .pt_root(pt_root),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_pa(rsp_pa), .rsp_fault(rsp_fault)
  );

  // behavioural memory holding the table tree
  logic [63:0] mem [logic [44:0]];
  bit          pend = 1'b0;
  int          lat_left = 0;
  logic [44:0] paddr = '0;

  function automatic logic [63:0] rd(input logic [44:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      pend          <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (pend) begin
        if (lat_left == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= rd(paddr);
          pend          <= 1'b0;
        end else lat_left <= lat_left - 1;
      end
      if (mem_req_valid && mem_req_ready) begin
        if (pend) multi_err <= 1'b1;
        pend     <= 1'b1;
        paddr    <= mem_req_addr;
        lat_left <= lat_cfg;
        nreads   <= nreads + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock monitor of the memory request port, then the acceptance pattern
  logic        pv = 1'b0, prdy = 1'b0;
  logic [44:0] pa_prev = '0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (pv && !prdy)
        chk(mem_req_valid && mem_req_addr == pa_prev, "R10 request held while stalled",
            {19'd0, mem_req_addr}, {19'd0, pa_prev});
      if (mem_req_valid && mem_req_addr[2:0] != 3'd0)
        chk(1'b0, "R2 entry address aligned to 8", {61'd0, mem_req_addr[2:0]}, 64'd0);
      if (multi_err) begin
        chk(1'b0, "R10 second read while one outstanding", 64'd1, 64'd0);
        multi_err = 1'b0;
      end
    end
    pv      = mem_req_valid;
    pa_prev = mem_req_addr;
    mem_req_ready = stall ? (cyc % 3 == 0) : 1'b1;
    prdy    = mem_req_ready;
  end

  function automatic logic [63:0] mkva(input int i1, input int i2, input int i3, input int off);
    logic [42:0] x;
    x = {i1[9:0], i2[9:0], i3[9:0], off[12:0]};
    return {{21{x[42]}}, x};
  endfunction

  function automatic logic [44:0] ent(input logic [44:0] base, input logic [9:0] idx);
    return base + {32'd0, idx, 3'd0};
  endfunction

  task automatic map(input logic [44:0] root, input logic [63:0] va,
                     input logic [31:0] l2, input logic [31:0] l3,
                     input logic [31:0] dp, input logic [3:0] fl);
    mem[ent(root, va[42:33])]          = {l2, 28'd0, 4'b0001};
    mem[ent({l2, 13'd0}, va[32:23])]   = {l3, 28'd0, 4'b0001};
    mem[ent({l3, 13'd0}, va[22:13])]   = {dp, 28'd0, fl};
  endtask

  // reference translation, written from the requirements
  task automatic ref_walk(input logic [63:0] va, input bit wr, input bit usr,
                          input logic [44:0] root, output logic [44:0] pa,
                          output logic [1:0] code, output int nrd);
    logic [21:0] up;
    logic [44:0] base;
    logic [63:0] e;
    bit          done;
    up = va[63:42]; pa = '0; code = 2'd0; nrd = 0; base = root; done = 1'b0;
    if (!(up == 22'd0 || up == '1)) code = 2'd2;
    else if (usr && va[42]) code = 2'd3;
    else if (va[42:41] == 2'b10) pa = {4'd0, va[40:0]};
    else begin
      for (int l = 0; l < 3; l++) begin
        if (!done) begin
          e = rd(ent(base, va[42-10*l -: 10]));
          nrd++;
          if (!e[0]) begin code = 2'd1; done = 1'b1; end
          else if (l < 2) base = {e[63:32], 13'd0};
          else if (!((wr ? e[2] : e[1]) && (!usr || e[3]))) code = 2'd3;
          else pa = {e[63:32], va[12:0]};
        end
      end
    end
  endtask

  task automatic run(input logic [63:0] va, input bit wr, input bit usr,
                     input int hold, input string tag);
    logic [44:0] epa, hpa;
    logic [1:0]  ecode, hcode;
    int          erd, r0, w;
    ref_walk(va, wr, usr, pt_root, epa, ecode, erd);
    @(negedge clk);
    r0 = nreads;
    req_valid = 1'b1; req_va = va; req_write = wr; req_user = usr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    w = 0;
    while (!rsp_valid && w < 400) begin @(negedge clk); w++; end
    chk(rsp_valid, {tag, " R11 response arrives"}, {63'd0, rsp_valid}, 64'd1);
    hpa = rsp_pa; hcode = rsp_fault;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready && rsp_pa == hpa && rsp_fault == hcode,
          {tag, " R11 response held"}, {19'd0, rsp_pa}, {19'd0, hpa});
    end
    chk(rsp_fault == ecode, {tag, " fault code"}, {62'd0, rsp_fault}, {62'd0, ecode});
    chk(rsp_pa == epa, {tag, " physical address"}, {19'd0, rsp_pa}, {19'd0, epa});
    chk(nreads - r0 == erd, {tag, " entry reads issued"}, 64'(nreads - r0), 64'(erd));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(req_ready && !rsp_valid, {tag, " R11 idle after handshake"},
        {62'd0, req_ready, rsp_valid}, 64'd2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] va_a, va_ro, va_s1, va_k;
    pt_root = 45'h10000;
    va_a  = mkva(5, 7, 9, 13'h123);
    va_ro = mkva(5, 7, 11, 13'h1ff0);
    va_s1 = mkva(10'h3f0, 2, 3, 13'h0a5);
    map(pt_root, va_a,  32'h100, 32'h200, 32'hABCDE, 4'b1111);
    map(pt_root, va_ro, 32'h100, 32'h200, 32'h13579, 4'b0011);
    map(pt_root, va_s1, 32'h300, 32'h301, 32'h7654, 4'b0111);
    map(45'h40000, va_a, 32'h500, 32'h501, 32'h2468, 4'b1011);

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset state",
        {61'd0, req_ready, rsp_valid, mem_req_valid}, 64'd4);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R5 full walk, user read and write
    run(va_a, 1'b0, 1'b1, 0, "R2 R3 R5 user read");
    run(va_a, 1'b1, 1'b1, 2, "R5 user write");
    // R2 different root table changes the result
    pt_root = 45'h40000;
    run(va_a, 1'b0, 1'b0, 0, "R2 alternate root");
    pt_root = 45'h10000;
    // R9 rights
    run(va_ro, 1'b0, 1'b0, 0, "R9 kernel read of read-only page");
    run(va_ro, 1'b1, 1'b0, 0, "R9 write to read-only page");
    run(va_ro, 1'b0, 1'b1, 0, "R9 user read of kernel page");
    // R4 invalid at each level
    run(mkva(9, 7, 9, 0), 1'b0, 1'b0, 0, "R4 invalid at level 1");
    run(mkva(5, 8, 9, 0), 1'b0, 1'b0, 0, "R4 invalid at level 2");
    run(mkva(5, 7, 10, 0), 1'b0, 1'b0, 0, "R4 invalid at level 3");
    // R6 non-canonical
    run(64'h0000_1000_0000_0000, 1'b0, 1'b0, 0, "R6 stray upper bit");
    run(64'h8000_0000_0000_1000, 1'b0, 1'b0, 1, "R6 top bit only");
    // R7 segments
    va_k = {21'h1FFFFF, 2'b10, 41'h1_2345_6789A};
    run(va_k, 1'b1, 1'b0, 0, "R7 kernel physical bypass");
    run(va_s1, 1'b1, 1'b0, 0, "R7 kernel virtual walk");
    // R8 user into kernel segments
    run(va_k, 1'b0, 1'b1, 0, "R8 user in physical segment");
    run(va_s1, 1'b0, 1'b1, 0, "R8 user in kernel virtual segment");
    // R10 stalled memory acceptance with longer latency
    stall = 1'b1; lat_cfg = 2;
    run(va_a, 1'b0, 1'b1, 3, "R10 stalled memory");
    run(mkva(5, 8, 1, 0), 1'b1, 1'b0, 0, "R10 R4 stalled invalid");
    stall = 1'b0; lat_cfg = 0;
    run(va_ro, 1'b0, 1'b0, 0, "R5 back to back");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule